// File: doc/BRIEF.md
# EEPROM Row-Latch Programming Controller

This block sits in front of a small data EEPROM array. Software does not write cells directly: it first sets a latch-enable bit in a two-bit control register, then writes bytes into the EEPROM address window. Each byte goes into the write latch of its column instead of the array. Writing the control register with the program bit set starts a timed programming cycle. At the end of that cycle every column that received a byte is written into one row of the array.

The target row is the upper part of the address of the most recent latched write. When a column is written twice before the latches clear, the latch keeps the bitwise AND of both bytes. The latches clear only when a programming cycle ends or when the latch-enable bit goes from 1 to 0. The array itself is a behavioural model that is erased (all ones) at reset. Reads are combinational from the array. During a programming cycle they return all ones.

Top module: `eeprom_rowlatch_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` is 2'b00, `busy` is 0, and every array byte reads 8'hFF.
- R2: In `ctl_wdata`/`ctl_rdata`, bit 0 is latch-enable and bit 1 is program. A window write made while latch-enable is 1 and no cycle is running stores the byte in the latch of column `mem_addr[4:0]`. The array contents read back unchanged.
- R3: When a programming cycle ends, each column written since the last clear is stored at row `mem_addr[6:5]` of the last latched write. All other bytes of the array keep their values.
- R4: A second latched write to a column before the latches clear leaves that column holding the AND of the old and the new byte.
- R5: `busy` is high for exactly PROG_CYC clock cycles after the control write that starts a cycle. While `busy` is high, `mem_rdata` is 8'hFF.
- R6: On the clock where the cycle ends, latch-enable and program both return to 0. All latches are emptied, so a later cycle with no new writes changes nothing.
- R7: Writing latch-enable from 1 to 0 discards every latched byte.
- R8: A program request is accepted only when latch-enable is already 1 and stays 1 in the same write. Otherwise no cycle starts and the program bit reads 0.
- R9: Control-register writes made while `busy` is high do not change `ctl_rdata` or shorten the cycle.
- R10: Window writes made while latch-enable is 0, or while `busy` is high, change neither the latches nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 latch-enable, bit 1 program |
| ctl_rdata | output | 2 | Control register read value |
| busy | output | 1 | High during the programming cycle |
| mem_wr | input | 1 | Window write strobe |
| mem_addr | input | 7 | Byte address: row in [6:5], column in [4:0] |
| mem_wdata | input | 8 | Window write data |
| mem_rdata | output | 8 | Array read data, combinational from `mem_addr` |

## Verification
`ctl_rdata`, `busy` and the latches change on the first rising edge after a write strobe. The bench therefore drives each strobe for one cycle from a falling edge and samples on the next falling edge. `mem_rdata` is combinational, so a read is sampled 1 ns after the address is set within the same low phase. The length of a cycle is measured by counting falling edges while `busy` is high, starting with the one right after the start write. Array contents are compared byte by byte only after `busy` has dropped, when the commit and the clearing of both control bits land on that same edge.

// File: rtl/eeprom_rl_pkg.sv
package eeprom_rl_pkg;
   localparam int unsigned CTL_W   = 2;
   localparam int unsigned CTL_LAT = 0;   // latch-enable bit position
   localparam int unsigned CTL_PGM = 1;   // program bit position
endpackage

// File: rtl/eeprom_rl_latch_bank.sv
// One write latch and valid flag per column; repeat writes merge by AND.
module eeprom_rl_latch_bank #(
   parameter int unsigned COLS   = 32,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned COL_W = $clog2(COLS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [COL_W-1:0]       wr_col,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   clr,
   output logic [COLS*DATA_W-1:0] lat_data,
   output logic [COLS-1:0]        lat_valid
);
   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic              hit;
      logic [DATA_W-1:0] d_q;
      logic              v_q;

      assign hit = wr_en && (wr_col == COL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (clr) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (hit) begin
            d_q <= v_q ? (d_q & wr_data) : wr_data;
            v_q <= 1'b1;
         end
      end

      assign lat_data[c*DATA_W +: DATA_W] = d_q;
      assign lat_valid[c]                 = v_q;
   end
endmodule

// File: rtl/eeprom_rl_prog_timer.sv
// Counts the programming cycle; done pulses on its last clock.
module eeprom_rl_prog_timer #(
   parameter int unsigned PROG_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   if (PROG_CYC == 1) begin : g_single
      assign done = run;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(PROG_CYC);
      logic [CNT_W-1:0] cnt_q;

      assign done = run && (cnt_q == CNT_W'(PROG_CYC - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (!run) cnt_q <= '0;
         else if (done) cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/eeprom_rl_cell_array.sv
// Behavioural cell array: erased at reset, one-row commit of valid columns.
module eeprom_rl_cell_array #(
   parameter int unsigned ROWS       = 4,
   parameter int unsigned COLS       = 32,
   parameter int unsigned DATA_W     = 8,
   parameter logic [7:0]  ERASED_VAL = 8'hFF,
   localparam int unsigned DEPTH     = ROWS * COLS,
   localparam int unsigned ROW_W     = $clog2(ROWS),
   localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [ROW_W-1:0]       row,
   input  logic [COLS*DATA_W-1:0] lat_data,
   input  logic [COLS-1:0]        lat_valid,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) cells[i] <= DATA_W'(ERASED_VAL);
      end else if (commit) begin
         for (int c = 0; c < int'(COLS); c++) begin
            if (lat_valid[c])
               cells[int'(row) * int'(COLS) + c] <= lat_data[c*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_rowlatch_ctrl.sv
module eeprom_rowlatch_ctrl
   import eeprom_rl_pkg::*;
#(
   parameter int unsigned ROWS       = 4,
   parameter int unsigned COLS       = 32,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PROG_CYC   = 16,
   parameter logic [7:0]  ERASED_VAL = 8'hFF,
   parameter logic [7:0]  BUSY_READ  = 8'hFF,
   localparam int unsigned DEPTH     = ROWS * COLS,
   localparam int unsigned COL_W     = $clog2(COLS),
   localparam int unsigned ROW_W     = $clog2(ROWS),
   localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              busy,
   input  logic              mem_wr,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] mem_rdata
);
   // elaboration-time parameter checks
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two, at least 2");
   end
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two, at least 2");
   end
   if (PROG_CYC < 1) begin : g_bad_cyc
      $error("PROG_CYC must be at least 1");
   end
   if (DATA_W < 1 || DATA_W > 8) begin : g_bad_dw
      $error("DATA_W must be 1 to 8");
   end

   logic               lat_q, pgm_q;
   logic [ROW_W-1:0]   row_q;
   logic               ctl_take, lat_fall, lat_wr, done, clr;
   logic [COLS*DATA_W-1:0] lat_data;
   logic [COLS-1:0]        lat_valid;
   logic [DATA_W-1:0]      cell_rd;

   assign ctl_take = ctl_wr && !pgm_q;
   assign lat_fall = ctl_take && lat_q && !ctl_wdata[CTL_LAT];
   assign lat_wr   = mem_wr && lat_q && !pgm_q;
   assign clr      = done || lat_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 1'b0;
         pgm_q <= 1'b0;
      end else if (done) begin
         lat_q <= 1'b0;
         pgm_q <= 1'b0;
      end else if (ctl_take) begin
         lat_q <= ctl_wdata[CTL_LAT];
         pgm_q <= ctl_wdata[CTL_PGM] && ctl_wdata[CTL_LAT] && lat_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (lat_wr) row_q <= mem_addr[ADDR_W-1:COL_W];
   end

   eeprom_rl_latch_bank #(.COLS(COLS), .DATA_W(DATA_W)) u_latches (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (lat_wr),
      .wr_col    (mem_addr[COL_W-1:0]),
      .wr_data   (mem_wdata),
      .clr       (clr),
      .lat_data  (lat_data),
      .lat_valid (lat_valid)
   );

   eeprom_rl_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (pgm_q),
      .done  (done)
   );

   eeprom_rl_cell_array #(
      .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ERASED_VAL(ERASED_VAL)
   ) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (done),
      .row       (row_q),
      .lat_data  (lat_data),
      .lat_valid (lat_valid),
      .rd_addr   (mem_addr),
      .rd_data   (cell_rd)
   );

   always_comb begin
      ctl_rdata          = '0;
      ctl_rdata[CTL_LAT] = lat_q;
      ctl_rdata[CTL_PGM] = pgm_q;
   end

   assign busy      = pgm_q;
   assign mem_rdata = pgm_q ? DATA_W'(BUSY_READ) : cell_rd;
endmodule

// File: rtl/eeprom_rl_checker.sv
module eeprom_rl_checker #(
   parameter int unsigned PROG_CYC = 16,
   parameter int unsigned DATA_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ctl_rdata,
   input logic              busy,
   input logic [DATA_W-1:0] mem_rdata
);
   int unsigned busy_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len_q <= 0;
      else if (busy) busy_len_q <= busy_len_q + 1;
      else           busy_len_q <= 0;
   end

   // R8: a running cycle always has latch-enable set
   p_pgm_with_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ctl_rdata == 2'b11));

   // R8: no cycle can start while latch-enable is clear
   p_no_start_unlatched_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[0] && !busy) |=> !busy);

   // R5: reads during the cycle return all ones
   p_busy_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mem_rdata == {DATA_W{1'b1}}));

   // R5: cycle length
   p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len_q == PROG_CYC));

   // R6: both control bits drop together at the end
   p_end_clears_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (ctl_rdata == 2'b00));
endmodule

bind eeprom_rowlatch_ctrl eeprom_rl_checker #(.PROG_CYC(PROG_CYC), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_rdata (ctl_rdata),
   .busy      (busy),
   .mem_rdata (mem_rdata)
);

// File: tb/eeprom_rowlatch_ctrl_test.sv
module eeprom_rowlatch_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int P          = 16;
   localparam int NCOL       = 32;
   localparam int DEPTH      = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [1:0] ctl_wdata = '0;
   logic [1:0] ctl_rdata;
   logic       busy;
   logic       mem_wr = 1'b0;
   logic [6:0] mem_addr = '0;
   logic [7:0] mem_wdata = '0;
   logic [7:0] mem_rdata;

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   logic [7:0] m_mem [DEPTH];
   logic [7:0] m_lat [NCOL];
   logic       m_vld [NCOL];
   int         m_row;
   logic       m_le, m_pg;

   eeprom_rowlatch_ctrl #(.PROG_CYC(P)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .busy(busy), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void clear_lat();
      for (int c = 0; c < NCOL; c++) begin m_lat[c] = 8'h00; m_vld[c] = 1'b0; end
   endfunction

   task automatic ctl_write(input logic [1:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      if (!m_pg) begin
         if (m_le && !v[0]) clear_lat();
         m_pg = v[1] && v[0] && m_le;
         m_le = v[0];
      end
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic mem_write(input int a, input logic [7:0] d);
      mem_wr = 1'b1; mem_addr = 7'(a); mem_wdata = d;
      if (m_le && !m_pg) begin
         m_lat[a % NCOL] = m_vld[a % NCOL] ? (m_lat[a % NCOL] & d) : d;
         m_vld[a % NCOL] = 1'b1;
         m_row = a / NCOL;
      end
      @(negedge clk);
      mem_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
      mem_addr = 7'(a);
      #1;
      chk(mem_rdata == exp, req, int'(mem_rdata), int'(exp));
   endtask

   // counts busy cycles (already_seen elapsed before the call), then commits the model
   task automatic wait_prog(input int already_seen);
      int n = already_seen;
      while (busy && n < 4*P) begin
         mem_addr = 7'($urandom_range(0, DEPTH-1));
         #1;
         chk(mem_rdata == 8'hFF, "R5 busy read", int'(mem_rdata), 8'hFF);
         n++;
         @(negedge clk);
      end
      chk(n == P, "R5 busy length", n, P);
      chk(ctl_rdata == 2'b00, "R6 ctl cleared", int'(ctl_rdata), 0);
      for (int c = 0; c < NCOL; c++)
         if (m_vld[c]) m_mem[m_row*NCOL + c] = m_lat[c];
      clear_lat();
      m_le = 1'b0; m_pg = 1'b0;
   endtask

   task automatic compare_all(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         rd_chk(a, m_mem[a], req);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
      clear_lat();
      m_le = 1'b0; m_pg = 1'b0; m_row = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(ctl_rdata == 2'b00, "R1 ctl", int'(ctl_rdata), 0);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      compare_all("R1 erased");

      // R2/R4/R3 latch, merge, program
      ctl_write(2'b01);
      chk(ctl_rdata == 2'b01, "R2 latch enable", int'(ctl_rdata), 1);
      mem_write(7'h25, 8'h3C);
      rd_chk(7'h25, 8'hFF, "R2 array untouched");
      mem_write(7'h25, 8'hF0);
      mem_write(7'h27, 8'hAA);
      ctl_write(2'b11);
      wait_prog(0);
      rd_chk(7'h25, 8'h30, "R4 AND merge");
      compare_all("R3 commit");

      // R6 latches empty after cycle
      ctl_write(2'b01);
      ctl_write(2'b11);
      wait_prog(0);
      compare_all("R6 latches cleared");

      // R7 falling latch-enable discards
      ctl_write(2'b01);
      mem_write(7'h10, 8'h00);
      ctl_write(2'b00);
      ctl_write(2'b01);
      ctl_write(2'b11);
      wait_prog(0);
      rd_chk(7'h10, 8'hFF, "R7 discarded");

      // R8 program without latch-enable
      ctl_write(2'b10);
      chk(busy == 1'b0, "R8 no start", int'(busy), 0);
      chk(ctl_rdata == 2'b00, "R8 pgm reads 0", int'(ctl_rdata), 0);
      ctl_write(2'b11);
      chk(busy == 1'b0, "R8 no start same write", int'(busy), 0);
      chk(ctl_rdata == 2'b01, "R8 only latch set", int'(ctl_rdata), 1);
      ctl_write(2'b00);

      // R10 write with latch off
      mem_write(7'h40, 8'h00);
      rd_chk(7'h40, 8'hFF, "R10 unlatched write ignored");

      // R9 / R10 during busy; R3 row from last write
      ctl_write(2'b01);
      mem_write(7'h01, 8'h11);
      mem_write(7'h62, 8'h22);
      ctl_write(2'b11);
      ctl_write(2'b00);
      chk(ctl_rdata == 2'b11, "R9 ctl write ignored", int'(ctl_rdata), 3);
      ctl_write(2'b01);
      chk(busy == 1'b1, "R9 cycle continues", int'(busy), 1);
      mem_write(7'h03, 8'h00);
      wait_prog(3);
      rd_chk(7'h61, 8'h11, "R3 row of last write");
      rd_chk(7'h01, 8'hFF, "R3 earlier row untouched");
      rd_chk(7'h03, m_mem[7'h03], "R10 busy write ignored");

      // random rounds
      for (int r = 0; r < 8; r++) begin
         int nw;
         int rw;
         ctl_write(2'b01);
         nw = $urandom_range(1, 14);
         rw = $urandom_range(0, 3);
         for (int k = 0; k < nw; k++) begin
            int col;
            if ($urandom_range(0, 5) == 0) rw = $urandom_range(0, 3);
            col = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 5) : $urandom_range(0, NCOL-1);
            mem_write(rw*NCOL + col, 8'($urandom()));
         end
         ctl_write(2'b11);
         wait_prog(0);
         compare_all("R3 R4 random round");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule